// File: doc/BRIEF.md
# Pin Change Interrupt Bank

A bank of general-purpose input pins watched for level changes. Each pin passes through a multi-flop synchroniser. Each pin can be armed separately for rising transitions, for falling transitions, or for both. When an armed transition is seen, a sticky per-pin status flag is latched.

All flags are ORed into one summary indication. A master enable turns that summary into a level interrupt request. When the master enable is set, a flag-setting transition also raises a one-cycle wake pulse for a low-power controller.

Software reaches the enables, the flags and the master enable through a small register port. Writes to the flag register can only clear flags: each flag is ANDed with the written bit. A transition that is detected in the same cycle as the write survives that write.

Top module: `ioc_bank`

## Requirements
- R1: While reset is asserted, every register reads zero (rising enables at address 0, falling enables at address 1, flags at address 2, control at address 3), and `irq_o` and `wake_o` are low.
- R2: With only the rising enable set for a pin, a 0-to-1 change on that pin sets its flag, and a 1-to-0 change leaves the flag unchanged.
- R3: With only the falling enable set for a pin, a 1-to-0 change on that pin sets its flag, and a 0-to-1 change leaves the flag unchanged.
- R4: With both enables set, a change in either direction sets the pin's flag.
- R5: A pin change applied between clock edges makes its flag readable just after the third rising clock edge that follows the change, and not before.
- R6: With the master enable (control bit 0) clear, armed changes still set flags, while `irq_o` and `wake_o` stay low.
- R7: Control bit 1 reads as the OR of all flags, and control bit 2 reads as the interrupt request. `irq_o` equals the master enable ANDed with that OR.
- R8: A write to the flag register clears each flag whose write-data bit is 0 and never sets a flag whose write-data bit is 1.
- R9: If an armed change is detected in the same cycle as a flag write that would clear that pin's flag, the flag ends set.
- R10: With the master enable set, `wake_o` is high for exactly one cycle, in the cycle in which the flag first becomes set.
- R11: A pin that is already high while reset is asserted produces no flag after reset is released, even if its rising enable is set in the first cycle after release.
- R12: Enable registers read back the value last written. The control register keeps only bit 0 as writable state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-running clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_i | input | NUM_PINS | Monitored pin levels, asynchronous to clk |
| addr_i | input | 2 | Register select |
| wr_en_i | input | 1 | Write strobe, one write per cycle |
| wdata_i | input | NUM_PINS | Write data |
| rdata_o | output | NUM_PINS | Read data for addr_i (combinational) |
| irq_o | output | 1 | Interrupt request level |
| wake_o | output | 1 | One-cycle wake pulse |

## Verification
The assertions assume that `pins_i` stays stable for at least the synchroniser depth plus one cycle between changes, so that each change is seen exactly once. They also assume that `addr_i` and `wdata_i` are stable whenever `wr_en_i` is high. The stimulus changes pins and register inputs only on falling clock edges, and it holds every pin level for at least three cycles. The same-cycle race between a write and a detected change is set up on purpose by timing the write to land on the third rising edge after a pin change.

// File: rtl/ioc_pkg.sv
package ioc_pkg;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_RISE_EN = 2'd0,
    REG_FALL_EN = 2'd1,
    REG_FLAGS   = 2'd2,
    REG_CTRL    = 2'd3
  } ioc_reg_e;

  localparam int unsigned CTRL_MASTER_BIT  = 0;
  localparam int unsigned CTRL_SUMMARY_BIT = 1;
  localparam int unsigned CTRL_IRQ_BIT     = 2;
endpackage

// File: rtl/ioc_sync.sv
module ioc_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/ioc_edge_det.sv
module ioc_edge_det #(
  parameter int unsigned W           = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cur_i,
  input  logic [W-1:0] pos_en_i,
  input  logic [W-1:0] neg_en_i,
  output logic [W-1:0] hit_o,
  output logic         armed_o
);
  localparam int unsigned ARM_CYC = SYNC_STAGES + 1;
  localparam int unsigned CNT_W   = $clog2(ARM_CYC + 1);

  logic [W-1:0]     prev_q;
  logic [CNT_W-1:0] arm_cnt_q;
  logic             armed;
  logic [W-1:0]     rise_w;
  logic [W-1:0]     fall_w;

  function automatic logic [W-1:0] rise_of(logic [W-1:0] now, logic [W-1:0] old);
    return now & ~old;
  endfunction

  function automatic logic [W-1:0] fall_of(logic [W-1:0] now, logic [W-1:0] old);
    return ~now & old;
  endfunction

  function automatic logic [W-1:0] armed_hits(logic [W-1:0] r, logic [W-1:0] f,
                                              logic [W-1:0] pe, logic [W-1:0] ne);
    return (r & pe) | (f & ne);
  endfunction

  // Prior sample follows the synchroniser every cycle; detection waits
  // until the synchroniser has flushed its reset value.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q    <= '0;
      arm_cnt_q <= '0;
    end else begin
      prev_q <= cur_i;
      if (!armed) arm_cnt_q <= arm_cnt_q + 1'b1;
    end
  end

  assign armed   = (arm_cnt_q == CNT_W'(ARM_CYC));
  assign armed_o = armed;
  assign rise_w  = armed ? rise_of(cur_i, prev_q) : '0;
  assign fall_w  = armed ? fall_of(cur_i, prev_q) : '0;
  assign hit_o   = armed_hits(rise_w, fall_w, pos_en_i, neg_en_i);

  // R2
  rise_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((hit_o & ~neg_en_i) != '0) |-> ((hit_o & ~neg_en_i & ~cur_i) == '0));

  // R3
  fall_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((hit_o & ~pos_en_i) != '0) |-> ((hit_o & ~pos_en_i & cur_i) == '0));
endmodule

// File: rtl/ioc_flag_reg.sv
module ioc_flag_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] hit_i,
  input  logic         wr_i,
  input  logic [W-1:0] wmask_i,
  output logic [W-1:0] flags_o,
  output logic         any_o
);
  logic [W-1:0] flags_q;

  function automatic logic [W-1:0] flag_next(logic [W-1:0] cur, logic wr,
                                             logic [W-1:0] mask, logic [W-1:0] hits);
    logic [W-1:0] kept;
    kept = wr ? (cur & mask) : cur;
    return kept | hits;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flag_next(flags_q, wr_i, wmask_i, hit_i);
  end

  assign flags_o = flags_q;
  assign any_o   = |flags_q;

  // R9
  hit_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_i != '0) |=> ((flags_q & $past(hit_i)) == $past(hit_i)));

  // R8
  no_write_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> ((flags_q & ~$past(flags_q) & ~$past(hit_i)) == '0));
endmodule

// File: rtl/ioc_bank.sv
module ioc_bank
  import ioc_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pins_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                wr_en_i,
  input  logic [NUM_PINS-1:0] wdata_i,
  output logic [NUM_PINS-1:0] rdata_o,
  output logic                irq_o,
  output logic                wake_o
);
  logic [NUM_PINS-1:0] pins_sync;
  logic [NUM_PINS-1:0] rise_en_q;
  logic [NUM_PINS-1:0] fall_en_q;
  logic [NUM_PINS-1:0] hit;
  logic [NUM_PINS-1:0] flags;
  logic                summary;
  logic                master_q;
  logic                wake_q;
  logic                armed;
  logic                wr_rise, wr_fall, wr_flags, wr_ctrl;
  ioc_reg_e            sel;

  assign sel      = ioc_reg_e'(addr_i);
  assign wr_rise  = wr_en_i && (sel == REG_RISE_EN);
  assign wr_fall  = wr_en_i && (sel == REG_FALL_EN);
  assign wr_flags = wr_en_i && (sel == REG_FLAGS);
  assign wr_ctrl  = wr_en_i && (sel == REG_CTRL);

  ioc_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(pins_i), .q_o(pins_sync)
  );

  ioc_edge_det #(.W(NUM_PINS), .SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .cur_i(pins_sync),
    .pos_en_i(rise_en_q), .neg_en_i(fall_en_q),
    .hit_o(hit), .armed_o(armed)
  );

  ioc_flag_reg #(.W(NUM_PINS)) u_flags (
    .clk(clk), .rst_n(rst_n), .hit_i(hit), .wr_i(wr_flags),
    .wmask_i(wdata_i), .flags_o(flags), .any_o(summary)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_en_q <= '0;
      fall_en_q <= '0;
      master_q  <= 1'b0;
      wake_q    <= 1'b0;
    end else begin
      if (wr_rise) rise_en_q <= wdata_i;
      if (wr_fall) fall_en_q <= wdata_i;
      if (wr_ctrl) master_q  <= wdata_i[CTRL_MASTER_BIT];
      wake_q <= master_q && (hit != '0);
    end
  end

  assign irq_o  = master_q && summary;
  assign wake_o = wake_q;

  always_comb begin
    rdata_o = '0;
    unique case (sel)
      REG_RISE_EN: rdata_o = rise_en_q;
      REG_FALL_EN: rdata_o = fall_en_q;
      REG_FLAGS:   rdata_o = flags;
      REG_CTRL: begin
        rdata_o[CTRL_MASTER_BIT]  = master_q;
        rdata_o[CTRL_SUMMARY_BIT] = summary;
        rdata_o[CTRL_IRQ_BIT]     = irq_o;
      end
      default:     rdata_o = '0;
    endcase
  end

  // R6
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !master_q |-> (!irq_o && !wake_o));

  // R10
  wake_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> (flags != '0));

  // R7
  summary_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flags == '0) |-> !irq_o);

  // R11
  quiet_warmup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> (flags == '0));
endmodule

// File: tb/ioc_bank_tb.sv
`timescale 1ns/1ps
module ioc_bank_tb;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] pins = '0;
  logic [1:0]   addr = '0;
  logic         wr_en = 1'b0;
  logic [N-1:0] wdata = '0;
  logic [N-1:0] rdata;
  logic         irq, wake;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct {
    logic [N-1:0] exp;
    string        tag;
  } sb_item_t;
  sb_item_t sb_q[$];

  always #2.5 clk = ~clk;

  ioc_bank #(.NUM_PINS(N), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .pins_i(pins), .addr_i(addr),
    .wr_en_i(wr_en), .wdata_i(wdata), .rdata_o(rdata),
    .irq_o(irq), .wake_o(wake)
  );

  task automatic check(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read values as the design presents them
  always begin
    @(posedge clk);
    #1;
    if (sb_q.size() > 0) begin
      sb_item_t it;
      it = sb_q.pop_front();
      check(it.tag, rdata, it.exp);
    end
  end

  task automatic rd(logic [1:0] a, logic [N-1:0] exp, string tag);
    sb_item_t it;
    @(negedge clk);
    addr = a;
    it.exp = exp;
    it.tag = tag;
    sb_q.push_back(it);
    @(posedge clk);
    #2;
  endtask

  task automatic wr(logic [1:0] a, logic [N-1:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // returns on the third falling edge after the change
  task automatic pin_set(logic [N-1:0] v);
    @(negedge clk);
    pins = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    pins = 8'hA5;
    repeat (3) @(negedge clk);
    // R1 reset state
    rd(2'd0, 8'h00, "R1 rise_en");
    rd(2'd1, 8'h00, "R1 fall_en");
    rd(2'd2, 8'h00, "R1 flags");
    rd(2'd3, 8'h00, "R1 ctrl");
    check("R1 irq", N'(irq), 8'h00);
    check("R1 wake", N'(wake), 8'h00);

    // R11: pins high through reset, enables set right after release
    @(negedge clk);
    rst_n = 1'b1;
    addr = 2'd0; wdata = 8'hFF; wr_en = 1'b1;
    @(negedge clk);
    addr = 2'd1;
    @(negedge clk);
    wr_en = 1'b0;
    repeat (6) @(negedge clk);
    rd(2'd2, 8'h00, "R11 no spurious flag");
    rd(2'd0, 8'hFF, "R12 rise_en readback");
    rd(2'd1, 8'hFF, "R12 fall_en readback");

    // quiet set-up
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h00);
    pin_set(8'h00);
    wr(2'd2, 8'h00);
    rd(2'd2, 8'h00, "R8 clear");
    wr(2'd0, 8'h05);
    wr(2'd1, 8'h06);
    wr(2'd3, 8'hFE);
    rd(2'd3, 8'h00, "R12 ctrl only bit0 kept");

    // R5 latency and R2 rise on pin 0
    @(negedge clk);
    addr = 2'd2;
    pins = 8'h01;
    @(negedge clk);
    check("R5 not after 1 edge", rdata, 8'h00);
    @(negedge clk);
    check("R5 not after 2 edges", rdata, 8'h00);
    @(negedge clk);
    check("R5 set after 3 edges", rdata, 8'h01);
    check("R6 no wake when master off", N'(wake), 8'h00);
    check("R6 no irq when master off", N'(irq), 8'h00);

    pin_set(8'h00);
    rd(2'd2, 8'h01, "R2 fall ignored on rise-only pin");
    pin_set(8'h02);
    rd(2'd2, 8'h01, "R3 rise ignored on fall-only pin");
    pin_set(8'h00);
    rd(2'd2, 8'h03, "R3 fall sets flag");
    pin_set(8'h04);
    rd(2'd2, 8'h07, "R4 rise on both-enabled pin");
    wr(2'd2, 8'hFB);
    rd(2'd2, 8'h03, "R8 zero bit clears one flag");
    pin_set(8'h00);
    rd(2'd2, 8'h07, "R4 fall on both-enabled pin");
    rd(2'd3, 8'h02, "R7 summary with master off");

    wr(2'd2, 8'hFF);
    rd(2'd2, 8'h07, "R8 write of ones changes nothing");
    wr(2'd2, 8'h00);
    rd(2'd2, 8'h00, "R8 full clear");
    rd(2'd3, 8'h00, "R7 summary low with no flags");

    // R10 wake pulse with master on
    wr(2'd3, 8'h01);
    rd(2'd3, 8'h01, "R12 master readback");
    pin_set(8'h01);
    check("R10 wake in set cycle", N'(wake), 8'h01);
    check("R7 irq with flag and master", N'(irq), 8'h01);
    @(negedge clk);
    check("R10 wake single cycle", N'(wake), 8'h00);
    check("R7 irq held", N'(irq), 8'h01);
    rd(2'd3, 8'h07, "R7 ctrl master summary irq");

    // R9 race: bit 2 flagged, then a clearing write lands with a rise on bit 0
    pin_set(8'h00);
    pin_set(8'h04);
    pin_set(8'h00);
    rd(2'd2, 8'h05, "R9 setup flags");
    @(negedge clk);
    pins = 8'h01;
    @(negedge clk);
    @(negedge clk);
    addr = 2'd2; wdata = 8'h00; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    rd(2'd2, 8'h01, "R9 edge survives clearing write");

    // R6 master off with flags pending
    wr(2'd3, 8'h00);
    @(negedge clk);
    check("R6 irq low with flag pending", N'(irq), 8'h00);
    pin_set(8'h00);
    pin_set(8'h02);
    pin_set(8'h00);
    check("R6 wake low on set", N'(wake), 8'h00);
    rd(2'd2, 8'h03, "R6 flags still set with master off");

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule